// File: doc/BRIEF.md
# Byte-Serial Synchronous Port with Write-Collision Detection

This block is a one-byte synchronous serial port that sits on a small register bus. Software configures it through a control register, starts or stages a byte through a data register, and follows progress through a status register. As a clock master it produces the serial clock from the system clock at one of four rates. As a clock slave it follows an externally driven serial clock, which is synchronised into the system clock domain. Both clock polarities, both clock phases and both bit orders are supported.

When a byte has been exchanged, the received byte is copied into a read buffer, a completion flag is raised and, if enabled, an interrupt is requested. A data-register write made while a byte is still moving is refused and raises a collision flag. Both flags are cleared by a two-step sequence: a status read that sees a flag set, followed by any access to the data register.

Top module: `spi_port`

## Requirements
- R1: The control register (address 0) reads back what was written and resets to 0x00. Its fields are bit 7 interrupt enable, bit 6 port enable, bit 5 LSB-first order, bit 4 master mode, bit 3 clock polarity (CPOL), bit 2 clock phase (CPHA) and bits 1:0 rate code. Status (address 1) and data (address 2) also read 0x00 after reset.
- R2: In master mode with the port enabled, a write to the data register while idle starts exactly one byte. The serial clock makes 16 edges, returns to its idle level and stops.
- R3: The serial clock output idles at the CPOL level. In master mode, rate codes 0, 1, 2 and 3 give a serial clock period of 4, 16, 64 and 128 system clocks, which is a half period of 2, 8, 32 and 64.
- R4: With bit 5 set, bit 0 of the byte is sent first. With bit 5 clear, bit 7 is sent first. The received byte is assembled in the same order.
- R5: With CPHA = 0, the first output bit is valid before the first clock edge and data is sampled on every leading edge. With CPHA = 1, the output changes on leading edges and is sampled on trailing edges.
- R6: At the end of each byte the received byte is copied to a read buffer, and data-register reads return it.
- R7: Status bit 7 is set when a byte completes. Bits 5:0 of the status register always read 0.
- R8: The interrupt output is high exactly while status bit 7 is set and the interrupt enable bit is 1.
- R9: A data-register write while a byte is in progress sets status bit 6 and leaves the outgoing byte unchanged.
- R10: Status bits 7 and 6 are cleared only by a data-register read or write that follows a status read which saw either of them set. A data access without such a status read leaves them unchanged.
- R11: When a flag-setting event and a clearing data access fall in the same cycle, the flag ends up set.
- R12: In slave mode the port shifts on the external serial clock and produces the same results whatever the rate code is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| sck_in | input | 1 | External serial clock, used in slave mode |
| sdi | input | 1 | Serial data in |
| sck_out | output | 1 | Serial clock generated in master mode, CPOL level otherwise |
| sdo | output | 1 | Serial data out |
| irq | output | 1 | Transfer-complete interrupt request |

## Verification
A collision and a flag clear can land in the same cycle. This happens when software reads the status register, sees a collision, and then writes the data register again while the same byte is still moving. The bench provokes this during a slow master transfer. It writes twice to cause a collision, reads the status, and then writes a third time, which both clears and sets the collision flag in one cycle. The following status read must still show bit 6 set, and the byte that comes out of the port must still be the first byte written.

// File: rtl/spi_port_pkg.sv
// Package: shared types, register addresses and rate arithmetic for spi_port.
// Assumes an 8-bit register bus with a 2-bit address.
package spi_port_pkg;

    localparam int DATA_W    = 8;
    localparam int DIV_W     = 8;
    localparam int BASE_HALF = 2;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    // Control register layout, most significant field first.
    typedef struct packed {
        logic       irq_en;
        logic       enable;
        logic       lsb_first;
        logic       master;
        logic       cpol;
        logic       cpha;
        logic [1:0] rate;
    } spi_ctrl_t;

    // Half period of the master serial clock in system clocks: 2, 8, 32, 64.
    function automatic logic [DIV_W-1:0] half_cycles(input logic [1:0] rate);
        int sh;
        sh = (rate == 2'd3) ? 5 : 2 * int'(rate);
        return DIV_W'(BASE_HALF << sh);
    endfunction

endpackage

// File: rtl/spi_clkgen.sv
// Module: master serial clock generator.
// Produces one tick per half period while run is high and marks each tick
// as a leading or a trailing edge. The phase restarts at 0 whenever run is low.
module spi_clkgen
    import spi_port_pkg::*;
#(
    parameter int CNT_W = DIV_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       sck_ph,
    output logic       lead_tick,
    output logic       trail_tick
);

    logic [CNT_W-1:0] cnt_q;
    logic             term;
    logic             tick;

    assign term       = (cnt_q == CNT_W'(half_cycles(rate) - 1'b1));
    assign tick       = run && term;
    assign lead_tick  = tick && !sck_ph;
    assign trail_tick = tick && sck_ph;

    // Half-period counter and clock phase toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q  <= '0;
            sck_ph <= 1'b0;
        end else if (term) begin
            cnt_q  <= '0;
            sck_ph <= ~sck_ph;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/spi_sck_sync.sv
// Module: external serial clock synchroniser and edge classifier.
// Assumes the external clock half period spans at least four system clocks.
// An edge leaving the CPOL level is a leading edge; one returning to it is trailing.
module spi_sck_sync #(
    parameter int SYNC_STAGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_in,
    input  logic cpol,
    output logic lead,
    output logic trail
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   chg;

    // Shift the external clock through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], sck_in};
    end

    assign chg   = sync_q[SYNC_STAGES-2] ^ sync_q[SYNC_STAGES-1];
    assign lead  = chg && (sync_q[SYNC_STAGES-1] == cpol);
    assign trail = chg && (sync_q[SYNC_STAGES-1] != cpol);

endmodule

// File: rtl/spi_shifter.sv
// Module: byte shift engine shared by master and slave modes.
// Takes leading and trailing edge pulses and decides the sample and change
// edges from CPHA. Counts bits and reports the end of each byte. In master
// mode the byte ends on the last trailing edge, so the clock is back at idle.
module spi_shifter
    import spi_port_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          master,
    input  logic          cpha,
    input  logic          lsb_first,
    input  logic          start,
    input  logic          lead,
    input  logic          trail,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          sdi,
    output logic          sdo,
    output logic          active,
    output logic          done,
    output logic [DW-1:0] rx_byte
);

    localparam int CW = $clog2(DW + 1);

    logic [CW-1:0] lead_cnt, smp_cnt;
    logic [DW-1:0] tx_sr, rx_sr, rx_next;
    logic          acc_lead, acc_trail, sample_ev, change_ev;

    assign acc_lead  = enable && lead && (active || !master);
    assign acc_trail = enable && trail && active;
    assign sample_ev = cpha ? acc_trail : acc_lead;
    assign change_ev = cpha ? (acc_lead && lead_cnt != '0) : acc_trail;
    assign done      = master ? (acc_trail && lead_cnt == CW'(DW))
                              : (sample_ev && smp_cnt == CW'(DW - 1));
    assign rx_next   = lsb_first ? {sdi, rx_sr[DW-1:1]} : {rx_sr[DW-2:0], sdi};
    assign sdo       = lsb_first ? tx_sr[0] : tx_sr[DW-1];

    // Transfer activity: raised by a master start or the first slave leading edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || done) active <= 1'b0;
        else if (start || (acc_lead && !active)) active <= 1'b1;
    end

    // Leading-edge and sample counters for the current byte.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || done || start) begin
            lead_cnt <= '0;
            smp_cnt  <= '0;
        end else begin
            if (acc_lead)  lead_cnt <= lead_cnt + 1'b1;
            if (sample_ev) smp_cnt  <= smp_cnt + 1'b1;
        end
    end

    // Outgoing byte: loaded only while idle, shifted on change edges.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_sr <= '0;
        else if (load && !active) tx_sr <= load_data;
        else if (change_ev) tx_sr <= lsb_first ? {1'b0, tx_sr[DW-1:1]} : {tx_sr[DW-2:0], 1'b0};
    end

    // Incoming byte: one bit per sample edge.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_sr <= '0;
        else if (sample_ev) rx_sr <= rx_next;
    end

    // Read buffer: copied at the end of each byte.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_byte <= '0;
        else if (done) rx_byte <= sample_ev ? rx_next : rx_sr;
    end

    AST_DONE_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (active || !master)); // R2
    AST_LEAD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        lead_cnt <= CW'(DW)); // R2
    AST_TX_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (active && load && !change_ev) |=> $stable(tx_sr)); // R9

endmodule

// File: rtl/spi_flags.sv
// Module: completion and collision flags with the two-step clear.
// A status read records whether any flag was set. The next data access then
// clears both flags. A set event wins over a clear in the same cycle.
module spi_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic done,
    input  logic col_set,
    input  logic stat_rd,
    input  logic data_acc,
    output logic cmp,
    output logic col
);

    logic arm_q;
    logic clear;

    assign clear = data_acc && arm_q;

    // Arm on a status read that sees a flag; disarm on any data access.
    always_ff @(posedge clk) begin
        if (!rst_n)        arm_q <= 1'b0;
        else if (stat_rd)  arm_q <= cmp || col;
        else if (data_acc) arm_q <= 1'b0;
    end

    // Completion flag: set by end of byte, cleared by an armed data access.
    always_ff @(posedge clk) begin
        if (!rst_n)     cmp <= 1'b0;
        else if (done)  cmp <= 1'b1;
        else if (clear) cmp <= 1'b0;
    end

    // Collision flag: set by a refused data write, cleared like cmp.
    always_ff @(posedge clk) begin
        if (!rst_n)       col <= 1'b0;
        else if (col_set) col <= 1'b1;
        else if (clear)   col <= 1'b0;
    end

    AST_CMP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmp) |-> $past(done)); // R7
    AST_COL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(col) |-> $past(col_set)); // R9
    AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmp) |-> $past(data_acc && arm_q)); // R10
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        col_set |=> col); // R11

endmodule

// File: rtl/spi_port.sv
// Module: register-mapped byte serial port (top).
// Decodes the register bus, holds the control register, picks the master or
// slave edge source and drives the interrupt. Reads have no side effect
// except the flag arming done in spi_flags.
module spi_port
    import spi_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_en,
    input  logic       bus_we,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       sck_in,
    input  logic       sdi,
    output logic       sck_out,
    output logic       sdo,
    output logic       irq
);

    spi_ctrl_t         ctrl_q;
    logic              wr, rd, ctrl_wr, stat_rd, data_wr, data_acc;
    logic              busy, done, start, cmp, col;
    logic              m_lead, m_trail, s_lead, s_trail, lead, trail, sck_ph;
    logic [DATA_W-1:0] rx_byte;

    assign wr       = bus_en && bus_we;
    assign rd       = bus_en && !bus_we;
    assign ctrl_wr  = wr && (bus_addr == ADDR_CTRL);
    assign stat_rd  = rd && (bus_addr == ADDR_STAT);
    assign data_wr  = wr && (bus_addr == ADDR_DATA);
    assign data_acc = bus_en && (bus_addr == ADDR_DATA);
    assign start    = data_wr && ctrl_q.enable && ctrl_q.master && !busy;
    assign lead     = ctrl_q.master ? m_lead  : s_lead;
    assign trail    = ctrl_q.master ? m_trail : s_trail;
    assign sck_out  = (ctrl_q.master && ctrl_q.enable) ? (ctrl_q.cpol ^ sck_ph) : ctrl_q.cpol;
    assign irq      = cmp && ctrl_q.irq_en;

    // Control register write.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= spi_ctrl_t'(bus_wdata);
    end

    // Read data multiplexer.
    always_comb begin
        case (bus_addr)
            ADDR_CTRL: bus_rdata = ctrl_q;
            ADDR_STAT: bus_rdata = {cmp, col, 6'b0};
            ADDR_DATA: bus_rdata = rx_byte;
            default:   bus_rdata = 8'h00;
        endcase
    end

    spi_clkgen u_clkgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (busy && ctrl_q.master),
        .rate       (ctrl_q.rate),
        .sck_ph     (sck_ph),
        .lead_tick  (m_lead),
        .trail_tick (m_trail)
    );

    spi_sck_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck_in (sck_in),
        .cpol   (ctrl_q.cpol),
        .lead   (s_lead),
        .trail  (s_trail)
    );

    spi_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (ctrl_q.enable),
        .master    (ctrl_q.master),
        .cpha      (ctrl_q.cpha),
        .lsb_first (ctrl_q.lsb_first),
        .start     (start),
        .lead      (lead),
        .trail     (trail),
        .load      (data_wr),
        .load_data (bus_wdata),
        .sdi       (sdi),
        .sdo       (sdo),
        .active    (busy),
        .done      (done),
        .rx_byte   (rx_byte)
    );

    spi_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .done     (done),
        .col_set  (data_wr && busy),
        .stat_rd  (stat_rd),
        .data_acc (data_acc),
        .cmp      (cmp),
        .col      (col)
    );

    AST_SCK_BACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ctrl_q.master && !ctrl_wr) |=> (sck_out == ctrl_q.cpol)); // R2
    AST_NO_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && busy) |=> busy || $past(done)); // R9

endmodule

// File: tb/spi_port_tb.sv
`timescale 1ns/1ps
// Bench: scoreboard of bytes expected on sdo, filled by the driver and drained
// by a line monitor that also acts as the far-end device on sdi.
module spi_port_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_en = 1'b0, bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       sck_drv = 1'b0, sdi_r = 1'b0;
    logic       sck_out, sdo, irq;
    logic       bench_master = 1'b1;
    logic       line_sck;

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic       mon_on = 1'b0;
    logic       m_cpol = 1'b0, m_cpha = 1'b0, m_lsb = 1'b0;
    logic [7:0] m_peer = 8'h00, cap = 8'h00;
    int         pk = 0, ci = 0, edges = 0, last_cyc = 0, half_seen = 0;
    logic [7:0] exp_q[$];

    localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;

    always #2.5 clk = ~clk;
    always @(negedge clk) cyc++;
    assign line_sck = bench_master ? sck_out : sck_drv;

    spi_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck_in(sck_drv), .sdi(sdi_r), .sck_out(sck_out), .sdo(sdo), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic bitof(input logic [7:0] b, input int i, input logic lsb);
        return lsb ? b[i] : b[7-i];
    endfunction

    function automatic int half_of(input logic [1:0] r);
        return (r == 2'd3) ? 64 : (2 << (2 * int'(r)));
    endfunction

    // Monitor and far-end model: sample sdo, drive sdi, pop expected bytes.
    always @(line_sck) begin
        if (mon_on) begin
            logic lead_e, smp;
            edges++;
            half_seen = cyc - last_cyc;
            last_cyc  = cyc;
            lead_e = (line_sck != m_cpol);
            smp    = m_cpha ? !lead_e : lead_e;
            if (smp) begin
                if (m_lsb) cap[ci] = sdo; else cap[7-ci] = sdo;
                ci++;
                if (ci == 8) begin
                    ci = 0;
                    if (exp_q.size() == 0) chk("R4 R5 unexpected sdo byte", cap, 8'hxx);
                    else chk("R4 R5 byte seen on sdo", cap, exp_q.pop_front());
                end
            end else if (m_cpha) begin
                if (pk < 8) sdi_r = bitof(m_peer, pk, m_lsb);
                pk++;
            end else begin
                pk++;
                if (pk < 8) sdi_r = bitof(m_peer, pk, m_lsb);
            end
        end
    end

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic arm_mon(input logic cpol, input logic cpha, input logic lsb, input logic [7:0] peer);
        m_cpol = cpol; m_cpha = cpha; m_lsb = lsb; m_peer = peer;
        pk = 0; ci = 0; edges = 0; last_cyc = cyc;
        sdi_r = bitof(peer, 0, lsb);
        mon_on = 1'b1;
    endtask

    task automatic poll_done(output logic [7:0] st);
        st = 8'h00;
        for (int i = 0; i < 3000 && !st[7]; i++) reg_read(A_STAT, st);
        if (!st[7]) chk("R2 byte never completed", 0, 1);
    endtask

    task automatic wait_irq();
        int i;
        for (i = 0; i < 6000 && !irq; i++) @(negedge clk);
        chk("R8 irq raised after byte", irq, 1'b1);
    endtask

    task automatic run_master(input logic cpol, input logic cpha, input logic lsb,
                              input logic [1:0] rate, input logic [7:0] tx, input logic [7:0] peer);
        logic [7:0] v;
        int         h;
        h = half_of(rate);
        reg_write(A_CTRL, {1'b0, 1'b1, lsb, 1'b1, cpol, cpha, rate});
        repeat (3) @(negedge clk);
        bench_master = 1'b1;
        arm_mon(cpol, cpha, lsb, peer);
        exp_q.push_back(tx);
        reg_write(A_DATA, tx);
        poll_done(v);
        chk("R7 status after master byte", v, 8'h80);
        chk("R8 irq stays low with enable clear", irq, 1'b0);
        repeat (4 * h) @(negedge clk);
        chk("R2 edge count of one byte", edges, 16);
        chk("R3 clock back at idle level", sck_out, cpol);
        chk("R3 half period for rate code", half_seen, h);
        reg_read(A_DATA, v);
        chk("R6 master received byte", v, peer);
        reg_read(A_STAT, v);
        chk("R10 flags cleared by status then data", v, 8'h00);
        mon_on = 1'b0;
    endtask

    task automatic run_slave(input logic cpol, input logic cpha, input logic lsb,
                             input logic [1:0] rate, input logic [7:0] tx, input logic [7:0] peer);
        logic [7:0] v;
        reg_write(A_CTRL, {1'b0, 1'b1, lsb, 1'b0, cpol, cpha, rate});
        sck_drv = cpol;
        repeat (6) @(negedge clk);
        bench_master = 1'b0;
        arm_mon(cpol, cpha, lsb, peer);
        exp_q.push_back(tx);
        reg_write(A_DATA, tx);
        repeat (4) @(negedge clk);
        for (int e = 0; e < 16; e++) begin
            repeat (10) @(negedge clk);
            sck_drv = ~sck_drv;
        end
        repeat (8) @(negedge clk);
        reg_read(A_STAT, v);
        chk("R12 R7 status after slave byte", v, 8'h80);
        reg_read(A_DATA, v);
        chk("R12 R6 slave received byte", v, peer);
        reg_read(A_STAT, v);
        chk("R10 slave flags cleared", v, 8'h00);
        mon_on = 1'b0;
        bench_master = 1'b1;
    endtask

    task automatic finish_run();
        if (exp_q.size() != 0) chk("R4 bytes left in scoreboard", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired, actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // Reset state (R1, R7, R8)
        reg_read(A_CTRL, v); chk("R1 control reset", v, 8'h00);
        reg_read(A_STAT, v); chk("R7 status reset", v, 8'h00);
        reg_read(A_DATA, v); chk("R1 data reset", v, 8'h00);
        chk("R3 sck idle low after reset", sck_out, 1'b0);
        chk("R8 irq low after reset", irq, 1'b0);

        // Control read-back with the port disabled (R1, R3)
        reg_write(A_CTRL, 8'hBE);
        reg_read(A_CTRL, v); chk("R1 control read-back", v, 8'hBE);
        chk("R3 sck idles at CPOL=1", sck_out, 1'b1);

        // Master bytes across modes, orders and rates (R2 to R6)
        run_master(1'b0, 1'b0, 1'b0, 2'd0, 8'hA5, 8'h3C);
        run_master(1'b0, 1'b1, 1'b1, 2'd1, 8'h81, 8'h7E);
        run_master(1'b1, 1'b0, 1'b1, 2'd2, 8'h96, 8'h01);
        run_master(1'b1, 1'b1, 1'b0, 2'd3, 8'h4D, 8'hE2);

        // Interrupt and clear without a status read (R8, R10)
        reg_write(A_CTRL, 8'hD0);
        repeat (3) @(negedge clk);
        arm_mon(1'b0, 1'b0, 1'b0, 8'h69);
        exp_q.push_back(8'hF0);
        reg_write(A_DATA, 8'hF0);
        wait_irq();
        reg_read(A_DATA, v); chk("R6 byte read via irq path", v, 8'h69);
        reg_read(A_STAT, v); chk("R10 data read alone does not clear", v, 8'h80);
        chk("R8 irq still high", irq, 1'b1);
        reg_read(A_DATA, v);
        reg_read(A_STAT, v); chk("R10 clear after status then data", v, 8'h00);
        chk("R8 irq low after clear", irq, 1'b0);
        mon_on = 1'b0;

        // Collision, and clear colliding with a new collision (R9, R11)
        reg_write(A_CTRL, 8'hD3);
        repeat (3) @(negedge clk);
        arm_mon(1'b0, 1'b0, 1'b0, 8'h5A);
        exp_q.push_back(8'hA5);
        reg_write(A_DATA, 8'hA5);
        reg_write(A_DATA, 8'h3C);
        reg_read(A_STAT, v); chk("R9 collision flag set", v, 8'h40);
        reg_write(A_DATA, 8'h11);
        reg_read(A_STAT, v); chk("R11 set wins over clear", v, 8'h40);
        wait_irq();
        reg_read(A_STAT, v); chk("R9 R7 both flags after byte", v, 8'hC0);
        reg_read(A_DATA, v); chk("R9 received byte intact", v, 8'h5A);
        reg_read(A_STAT, v); chk("R10 both flags cleared", v, 8'h00);
        mon_on = 1'b0;

        // Slave mode with differing rate codes (R12, R4, R5)
        run_slave(1'b0, 1'b0, 1'b0, 2'd3, 8'hC3, 8'h5B);
        run_slave(1'b1, 1'b1, 1'b1, 2'd0, 8'h2F, 8'hD4);
        run_slave(1'b0, 1'b1, 1'b0, 2'd2, 8'h17, 8'hB8);
        run_slave(1'b1, 1'b0, 1'b1, 2'd1, 8'h6E, 8'h93);

        finish_run();
    end

endmodule